// File: doc/BRIEF.md
# Serial EEPROM Write and Protection Front End

This block is the slave side of a two-wire serial bus sitting in front of a 256-byte nonvolatile array. It samples the open-drain clock and data lines on the system clock, and it recognises start and stop conditions. It shifts in a control byte, an address byte and one or more data bytes, and it pulls the data line low in each acknowledge slot it accepts. A completed write is handed to a write engine. The engine then runs a fixed busy interval, and at its start it issues one memory write strobe per buffered byte.

Control bytes whose type nibble is the protection code do not write memory. Instead they act on protection flags that guard addresses below 128:
- set a software lock;
- clear the software lock;
- set a permanent lock.

The software lock is cleared by the functional reset. The permanent lock is loaded only by the power-on reset, from a test input that stands in for the stored nonvolatile bit.

Frame states:
- `S_IDLE`: waits for a start.
- `S_CTRL`: shifts in the control byte.
- `S_CTRL_ACK`: decides whether to acknowledge the control byte.
- `S_ADDR` and `S_ADDR_ACK`: shift in and acknowledge the address byte.
- `S_DATA` and `S_DATA_ACK`: shift in and acknowledge each data byte.

Transitions:
- A start moves any state to `S_CTRL`.
- A stop moves any state to `S_IDLE`.
- The busy interval forces `S_IDLE`.
- The eighth rising clock edge moves each shift state to its ack state.
- The falling edge that ends an accepted ack slot moves on to the next shift state (`S_CTRL_ACK`→`S_ADDR`, `S_ADDR_ACK`→`S_DATA`, `S_DATA_ACK`→`S_DATA`).
- A refused control byte moves `S_CTRL_ACK` to `S_IDLE`.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: A control byte is acknowledged only when bit 0 (R/W) is 0 and bits 7:4 are either 4'b1010 (memory write, bits 3:1 ignored) or 4'b0110 (protection command). Every other control byte is refused, and the slave leaves the frame.
- R2: After an accepted memory control byte, the address byte and every data byte are acknowledged. Byte k of the frame (k from 0) targets the address whose bits 7:2 come from the address byte and whose bits 1:0 are (address + k) mod 4. A later byte for the same slot replaces an earlier one.
- R3: Memory strobes are issued only when a stop arrives in the slot right after the acknowledge of a data byte. A stop after the address ack, or after one or more bits of a further byte, writes nothing.
- R4: For BUSY_CYC clocks after a committing stop, nothing is acknowledged and a frame that starts inside the interval is ignored to its end.
- R5: Protection code 3'b001 in control bits 3:1 sets the software lock. It is accepted only with the high-voltage indication asserted and both straps low. The address and data bytes it carries are ignored and write nothing.
- R6: Protection code 3'b011 clears the software lock. It is accepted only with the high-voltage indication asserted, strap A1 high and strap A2 low.
- R7: Protection code 3'b000 sets the permanent lock. It is accepted only with both straps low.
- R8: A data write to an address below 128 is acknowledged but produces no strobe while either lock is set. Addresses from 128 upward are still written.
- R9: While the permanent lock is set, every control byte with type nibble 4'b0110 is refused.
- R10: The functional reset does not touch the permanent lock. Power-on reset loads it from `por_perm_init`.
- R11: The functional reset clears the software lock.
- R12: Out of reset, `sda_oe` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Functional reset, active low, synchronous |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| por_perm_init | input | 1 | Permanent-lock value loaded at power-on reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe | output | 1 | High pulls the data line low |
| a0_hv | input | 1 | High voltage present on the A0 pin |
| a1_strap | input | 1 | A1 strap level |
| a2_strap | input | 1 | A2 strap level |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | ADDR_W | Address for the strobe |
| mem_wdata | output | 8 | Data for the strobe |

## Verification
The bench builds the block with PAGE_BYTES=4 and BUSY_CYC=600, with a bus bit period of 32 system clocks. This busy interval is longer than the time needed to shift a whole control byte. A frame started right after a commit therefore reaches its acknowledge slot while the engine is still busy, and the refusal can be seen on the data line. Four-byte pages with frames of up to six bytes exercise slot rollover and overwrite. The default lock boundary of 128 splits the array, so protected and unprotected writes can be mixed in one random run.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL,
        S_CTRL_ACK,
        S_ADDR,
        S_ADDR_ACK,
        S_DATA,
        S_DATA_ACK
    } frm_state_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_LOCK_SW,
        CMD_UNLOCK_SW,
        CMD_LOCK_PERM
    } prot_cmd_t;

    localparam logic [2:0] CODE_LOCK_SW   = 3'b001;
    localparam logic [2:0] CODE_UNLOCK_SW = 3'b011;
    localparam logic [2:0] CODE_LOCK_PERM = 3'b000;

endpackage

// File: rtl/eewp_bus_sync.sv
module eewp_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eewp_frame.sv
module eewp_frame
    import eewp_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          PAGE_W    = 2,
    parameter logic [3:0]  MEM_TYPE  = 4'b1010,
    parameter logic [3:0]  PROT_TYPE = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy,
    input  logic              perm_wp,
    input  logic              a0_hv,
    input  logic              a1_strap,
    input  logic              a2_strap,
    output logic              sda_oe,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic              commit,
    output logic              commit_prot,
    output prot_cmd_t         commit_cmd
);
    frm_state_t        state, nxt;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic              ack_drv;
    logic              is_prot;
    prot_cmd_t         cmd;
    logic [ADDR_W-1:0] addr_ptr;
    logic              data_seen;

    logic              byte_done;
    logic              shifting;
    logic              ctrl_ok;
    logic              ctrl_prot;
    prot_cmd_t         ctrl_cmd;

    assign byte_done = scl_rise && (bit_cnt == 4'd7);
    assign shifting  = (state == S_CTRL) || (state == S_ADDR) || (state == S_DATA);

    // control byte decode, evaluated on the complete byte held in shreg
    always_comb begin
        ctrl_cmd = CMD_NONE;
        unique case (shreg[3:1])
            CODE_LOCK_SW:   if (a0_hv && !a1_strap && !a2_strap) ctrl_cmd = CMD_LOCK_SW;
            CODE_UNLOCK_SW: if (a0_hv && a1_strap && !a2_strap)  ctrl_cmd = CMD_UNLOCK_SW;
            CODE_LOCK_PERM: if (!a1_strap && !a2_strap)          ctrl_cmd = CMD_LOCK_PERM;
            default:        ctrl_cmd = CMD_NONE;
        endcase
        ctrl_prot = (shreg[7:4] == PROT_TYPE) && !shreg[0] && !perm_wp
                    && (ctrl_cmd != CMD_NONE);
        ctrl_ok   = ((shreg[7:4] == MEM_TYPE) && !shreg[0]) || ctrl_prot;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (busy) begin
            nxt = S_IDLE;
        end else if (start_det) begin
            nxt = S_CTRL;
        end else if (stop_det) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:     nxt = S_IDLE;
                S_CTRL:     if (byte_done) nxt = S_CTRL_ACK;
                S_CTRL_ACK: if (scl_fall) begin
                                if (ack_drv)       nxt = S_ADDR;
                                else if (!ctrl_ok) nxt = S_IDLE;
                            end
                S_ADDR:     if (byte_done) nxt = S_ADDR_ACK;
                S_ADDR_ACK: if (scl_fall && ack_drv) nxt = S_DATA;
                S_DATA:     if (byte_done) nxt = S_DATA_ACK;
                S_DATA_ACK: if (scl_fall && ack_drv) nxt = S_DATA;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            ack_drv   <= 1'b0;
            is_prot   <= 1'b0;
            cmd       <= CMD_NONE;
            addr_ptr  <= '0;
            data_seen <= 1'b0;
            buf_clr   <= 1'b0;
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_data  <= '0;
            commit    <= 1'b0;
        end else begin
            buf_clr <= 1'b0;
            buf_we  <= 1'b0;
            commit  <= 1'b0;
            if (busy) begin
                ack_drv <= 1'b0;
                bit_cnt <= '0;
            end else if (start_det) begin
                bit_cnt   <= '0;
                ack_drv   <= 1'b0;
                data_seen <= 1'b0;
                buf_clr   <= 1'b1;
            end else if (stop_det) begin
                ack_drv <= 1'b0;
                commit  <= (state == S_DATA) && data_seen && (bit_cnt == 4'd1);
            end else begin
                if (scl_rise && shifting) begin
                    shreg   <= {shreg[6:0], sda_s};
                    bit_cnt <= bit_cnt + 4'd1;
                end
                unique case (state)
                    S_CTRL_ACK: if (scl_fall) begin
                                    if (!ack_drv) begin
                                        if (ctrl_ok) begin
                                            ack_drv <= 1'b1;
                                            is_prot <= ctrl_prot;
                                            cmd     <= ctrl_cmd;
                                        end
                                    end else begin
                                        ack_drv <= 1'b0;
                                        bit_cnt <= '0;
                                    end
                                end
                    S_ADDR_ACK: if (scl_fall) begin
                                    if (!ack_drv) begin
                                        ack_drv  <= 1'b1;
                                        addr_ptr <= shreg[ADDR_W-1:0];
                                    end else begin
                                        ack_drv <= 1'b0;
                                        bit_cnt <= '0;
                                    end
                                end
                    S_DATA_ACK: if (scl_fall) begin
                                    if (!ack_drv) begin
                                        ack_drv <= 1'b1;
                                        if (!is_prot) begin
                                            buf_we   <= 1'b1;
                                            buf_addr <= addr_ptr;
                                            buf_data <= shreg;
                                            addr_ptr <= {addr_ptr[ADDR_W-1:PAGE_W],
                                                         addr_ptr[PAGE_W-1:0] + 1'b1};
                                        end
                                    end else begin
                                        ack_drv   <= 1'b0;
                                        bit_cnt   <= '0;
                                        data_seen <= 1'b1;
                                    end
                                end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe      = ack_drv;
    assign commit_prot = is_prot;
    assign commit_cmd  = cmd;

    // R4: no acknowledge is driven while the write engine is busy
    assert_no_ack_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R3: a commit only follows a stop seen in the data phase
    assert_commit_from_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(state == S_DATA));

    // R9: a protection control byte is never acknowledged under the permanent lock
    assert_perm_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CTRL_ACK && sda_oe && is_prot) |-> !perm_wp);

endmodule

// File: rtl/eewp_prot_regs.sv
module eewp_prot_regs
    import eewp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      por_n,
    input  logic      por_perm_init,
    input  logic      apply,
    input  prot_cmd_t cmd,
    output logic      sw_wp,
    output logic      perm_wp
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_wp <= 1'b0;
        end else if (apply) begin
            unique case (cmd)
                CMD_LOCK_SW:   sw_wp <= 1'b1;
                CMD_UNLOCK_SW: sw_wp <= 1'b0;
                default:       sw_wp <= sw_wp;
            endcase
        end
    end

    // only the power-on reset loads this flag
    always_ff @(posedge clk) begin
        if (!por_n) begin
            perm_wp <= por_perm_init;
        end else if (apply && cmd == CMD_LOCK_PERM) begin
            perm_wp <= 1'b1;
        end
    end

    // R10: once set, the permanent lock stays set until power-on reset
    assert_perm_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
        $past(perm_wp) |-> perm_wp);

    // R5: the software lock only rises on an applied lock command
    assert_sw_rise_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_wp) |-> $past(apply && cmd == CMD_LOCK_SW));

endmodule

// File: rtl/eewp_write_engine.sv
module eewp_write_engine #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 4,
    parameter int BUSY_CYC   = 64,
    parameter int PROT_BOUND = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_clr,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    input  logic              commit,
    input  logic              prot_any,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int CNT_W  = $clog2(BUSY_CYC + 1);

    logic              vld      [PAGE_BYTES];
    logic [ADDR_W-1:0] ent_addr [PAGE_BYTES];
    logic [7:0]        ent_data [PAGE_BYTES];
    logic [CNT_W-1:0]  cnt;
    logic [PAGE_W-1:0] slot;
    logic              in_emit;
    logic              locked;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g]      <= 1'b0;
                ent_addr[g] <= '0;
                ent_data[g] <= '0;
            end else if (buf_clr) begin
                vld[g] <= 1'b0;
            end else if (buf_we && buf_addr[PAGE_W-1:0] == PAGE_W'(g)) begin
                vld[g]      <= 1'b1;
                ent_addr[g] <= buf_addr;
                ent_data[g] <= buf_data;
            end
        end
    end

    assign slot    = cnt[PAGE_W-1:0];
    assign in_emit = busy && (cnt < CNT_W'(PAGE_BYTES));
    assign locked  = prot_any && ({1'b0, ent_addr[slot]} < (ADDR_W+1)'(PROT_BOUND));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (commit && !busy) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == CNT_W'(BUSY_CYC - 1)) busy <= 1'b0;
                cnt <= cnt + 1'b1;
            end
            if (in_emit) begin
                mem_we    <= vld[slot] && !locked;
                mem_addr  <= ent_addr[slot];
                mem_wdata <= ent_data[slot];
            end
        end
    end

    // R3: strobes occur only inside the busy interval started by a commit
    assert_we_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R4: the frame logic never commits while the engine is busy
    assert_commit_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);

endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
    import eewp_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 4,
    parameter int BUSY_CYC   = 64,
    parameter int PROT_BOUND = 128,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              por_perm_init,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              a0_hv,
    input  logic              a1_strap,
    input  logic              a2_strap,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic              core_rst_n;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, sw_wp, perm_wp;
    logic              buf_clr, buf_we, commit, commit_prot;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0]        buf_data;
    prot_cmd_t         commit_cmd;

    assign core_rst_n = rst_n & por_n;

    eewp_bus_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eewp_frame #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_frame (
        .clk         (clk),
        .rst_n       (core_rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .busy        (busy),
        .perm_wp     (perm_wp),
        .a0_hv       (a0_hv),
        .a1_strap    (a1_strap),
        .a2_strap    (a2_strap),
        .sda_oe      (sda_oe),
        .buf_clr     (buf_clr),
        .buf_we      (buf_we),
        .buf_addr    (buf_addr),
        .buf_data    (buf_data),
        .commit      (commit),
        .commit_prot (commit_prot),
        .commit_cmd  (commit_cmd)
    );

    eewp_prot_regs u_prot (
        .clk           (clk),
        .rst_n         (core_rst_n),
        .por_n         (por_n),
        .por_perm_init (por_perm_init),
        .apply         (commit && commit_prot && !busy),
        .cmd           (commit_cmd),
        .sw_wp         (sw_wp),
        .perm_wp       (perm_wp)
    );

    eewp_write_engine #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .BUSY_CYC   (BUSY_CYC),
        .PROT_BOUND (PROT_BOUND)
    ) u_engine (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .buf_clr   (buf_clr),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .commit    (commit),
        .prot_any  (sw_wp | perm_wp),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R12: the data line is released whenever the core is in reset
    assert_released_in_reset_R12: assert property (@(posedge clk)
        !core_rst_n |=> !sda_oe);

endmodule

// File: tb/eeprom_wp_ctrl_tb_top.sv
module eeprom_wp_ctrl_tb_top;
    localparam int PB   = 4;
    localparam int BUSY = 600;
    localparam int Q    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic       por_perm_init = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       a0_hv = 1'b0;
    logic       a1 = 1'b0;
    logic       a2 = 1'b0;
    logic       sda_oe, mem_we;
    logic [7:0] mem_addr, mem_wdata;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] obs [256];
    logic [7:0] expm [256];
    bit exp_sw = 0;
    bit exp_perm = 0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    eeprom_wp_ctrl #(.PAGE_BYTES(PB), .BUSY_CYC(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .por_perm_init(por_perm_init),
        .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .a0_hv(a0_hv), .a1_strap(a1), .a2_strap(a2),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) if (mem_we) obs[mem_addr] <= mem_wdata;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = ~sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic frame(input logic [7:0] c, input logic [7:0] a, input int n,
                         input logic [47:0] d, input int extra,
                         output logic ac, output logic aa, output logic ad);
        logic k;
        bus_start();
        send_byte(c, ac);
        aa = 1'b0; ad = 1'b0;
        if (ac) begin
            send_byte(a, aa);
            ad = 1'b1;
            for (int i = 0; i < n; i++) begin
                send_byte(d[8*i +: 8], k);
                ad = ad & k;
            end
            for (int i = 0; i < extra; i++) send_bit(1'b0);
        end
        bus_stop();
    endtask

    task automatic settle();
        repeat (BUSY + 40) @(negedge clk);
    endtask

    function automatic bit is_locked(input logic [7:0] a);
        return (exp_sw || exp_perm) && (a < 8'd128);
    endfunction

    task automatic model_write(input logic [7:0] a, input int n, input logic [47:0] d);
        logic [7:0] p;
        p = a;
        for (int i = 0; i < n; i++) begin
            if (!is_locked(p)) expm[p] = d[8*i +: 8];
            p = (p & ~8'(PB-1)) | ((p + 8'd1) & 8'(PB-1));
        end
    endtask

    task automatic compare_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 256; i++) begin
            if (obs[i] !== expm[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, {first, obs[first]}, {first, expm[first]});
    endtask

    task automatic mem_write(input logic [7:0] a, input int n, input logic [47:0] d,
                             input int extra, input string req);
        logic ac, aa, ad;
        frame(8'hA0, a, n, d, extra, ac, aa, ad);
        check(ac && aa && ad, req, {ac, aa, ad}, 3'b111);
        if (extra == 0) model_write(a, n, d);
        settle();
        compare_mem(req);
    endtask

    task automatic prot_cmd(input logic [7:0] c, input bit hv, input bit s1, input bit s2,
                            input bit expect_ack, input string req);
        logic ac, aa, ad;
        a0_hv = hv; a1 = s1; a2 = s2;
        frame(c, 8'h05, 1, 48'h3C, 0, ac, aa, ad);
        check(ac == expect_ack, req, ac, expect_ack);
        if (ac) begin
            if (c[3:1] == 3'b001) exp_sw = 1;
            if (c[3:1] == 3'b011) exp_sw = 0;
            if (c[3:1] == 3'b000) exp_perm = 1;
        end
        a0_hv = 0; a1 = 0; a2 = 0;
        settle();
        compare_mem(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ac, aa, ad;
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) begin obs[i] = 8'h00; expm[i] = 8'h00; end
        repeat (10) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        repeat (4) @(negedge clk);

        // R12: reset state
        check(sda_oe == 1'b0, "R12", sda_oe, 0);
        check(mem_we == 1'b0, "R12", mem_we, 0);

        // R1 R2 R3: byte write and page rollover
        mem_write(8'h10, 1, 48'hA5, 0, "R2");
        mem_write(8'h46, 6, 48'h665544332211, 0, "R2");

        // R1: read bit set and foreign type are refused
        frame(8'hA1, 8'h00, 1, 48'h77, 0, ac, aa, ad);
        check(ac == 1'b0, "R1", ac, 0);
        frame(8'h50, 8'h00, 1, 48'h77, 0, ac, aa, ad);
        check(ac == 1'b0, "R1", ac, 0);
        settle();
        compare_mem("R1");

        // R3: stop after address ack and after partial byte write nothing
        frame(8'hA0, 8'h20, 0, 48'h0, 0, ac, aa, ad);
        check(ac && aa, "R3", {ac, aa}, 2'b11);
        mem_write(8'h21, 1, 48'h99, 3, "R3");
        mem_write(8'h22, 2, 48'h8877, 1, "R3");

        // R4: frame started during busy is ignored
        frame(8'hA0, 8'h30, 1, 48'h12, 0, ac, aa, ad);
        model_write(8'h30, 1, 48'h12);
        frame(8'hA0, 8'h31, 1, 48'h34, 0, ac, aa, ad);
        check(ac == 1'b0, "R4", ac, 0);
        settle();
        compare_mem("R4");

        // R5: lock needs high voltage and low straps
        prot_cmd(8'h62, 0, 0, 0, 0, "R5");
        prot_cmd(8'h62, 1, 1, 0, 0, "R5");
        prot_cmd(8'h62, 1, 0, 0, 1, "R5");
        mem_write(8'h20, 1, 48'hDE, 0, "R8");
        mem_write(8'h90, 1, 48'hAD, 0, "R8");

        // R6: unlock needs high voltage, A1 high, A2 low
        prot_cmd(8'h66, 1, 0, 0, 0, "R6");
        prot_cmd(8'h66, 1, 1, 1, 0, "R6");
        prot_cmd(8'h66, 1, 1, 0, 1, "R6");
        mem_write(8'h20, 1, 48'hBE, 0, "R6");

        // R11: functional reset clears the software lock
        prot_cmd(8'h62, 1, 0, 0, 1, "R11");
        @(negedge clk); rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1;
        exp_sw = 0;
        repeat (4) @(negedge clk);
        mem_write(8'h24, 1, 48'h5A, 0, "R11");

        // constrained random mix of writes and lock commands
        for (int it = 0; it < 18; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op == 0) prot_cmd(8'h62, 1, 0, 0, 1, "R5");
            else if (op == 1) prot_cmd(8'h66, 1, 1, 0, 1, "R6");
            else begin
                logic [7:0] ra;
                int rn, rx;
                logic [47:0] rd;
                ra = 8'($urandom);
                rn = 1 + int'($urandom % 6);
                rd = {16'($urandom), 32'($urandom)};
                rx = (($urandom % 4) == 0) ? 1 + int'($urandom % 7) : 0;
                mem_write(ra, rn, rd, rx, "R8");
            end
        end

        // R7: permanent lock, refused with a strap high, accepted with both low
        prot_cmd(8'h60, 0, 1, 0, 0, "R7");
        prot_cmd(8'h60, 0, 0, 0, 1, "R7");
        mem_write(8'h30, 1, 48'hC3, 0, "R7");
        mem_write(8'hC0, 1, 48'h3C, 0, "R8");

        // R9: every protection type byte is refused now
        prot_cmd(8'h66, 1, 1, 0, 0, "R9");
        prot_cmd(8'h62, 1, 0, 0, 0, "R9");

        // R10: functional reset keeps the permanent lock
        @(negedge clk); rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1;
        exp_sw = 0;
        repeat (4) @(negedge clk);
        mem_write(8'h31, 1, 48'h44, 0, "R10");

        // R10: power-on reset reloads from the test input
        @(negedge clk); por_perm_init = 1'b1; por_n = 1'b0;
        repeat (3) @(negedge clk); por_n = 1'b1;
        repeat (4) @(negedge clk);
        mem_write(8'h32, 1, 48'h45, 0, "R10");
        @(negedge clk); por_perm_init = 1'b0; por_n = 1'b0;
        repeat (3) @(negedge clk); por_n = 1'b1;
        exp_perm = 0;
        repeat (4) @(negedge clk);
        mem_write(8'h33, 1, 48'h46, 0, "R10");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule